// File: doc/BRIEF.md
# DAC trigger and DMA sequencer

This block is the digital front end of one 12-bit DAC channel. Software or a DMA controller writes a holding register over a simple synchronous register bus. The block then moves that value into the output data register that feeds the converter. The move happens in one of two ways. With triggering off, every write to the holding register reaches the output straight away. With triggering on, the value is copied on each active event from the selected trigger source: one of seven hardware pulse inputs, or a software trigger bit that clears itself.

When DMA is enabled, each accepted trigger raises a DMA request level, and the acknowledge pulse drops it again. If a trigger arrives while the previous request is still waiting for its acknowledge, the block records an underflow. That trigger is dropped and a sticky flag is set. The flag can drive an interrupt. From then on the channel ignores every trigger until software turns DMA enable off and back on.

Top module: `dacseq_top`

## Requirements
- R1: After reset the output data, the DMA request and the interrupt are 0, and the control, status and software-trigger registers read 0.
- R2: Control bits [3:1] select the trigger source. Codes 0 to 6 pick hardware input hw_trig[code], where code 6 is the external line, and code 7 picks the software trigger bit.
- R3: With trigger enable (control bit 0) set, the output takes the holding value only on an event from the selected source. A write to the holding register (address 1), or an event on any other source, leaves the output unchanged.
- R4: With trigger enable clear, a write to the holding register sets the output to the written value at the same clock edge, and trigger events have no effect.
- R5: Writing 1 to bit 0 of address 2 sets the software trigger bit. The bit reads back 1 until it is consumed, which happens at the first edge where trigger enable is set and code 7 is selected. The output then takes the holding value and the bit reads 0.
- R6: Each hardware input passes through a two-flop synchroniser and is edge-detected. One rising edge causes one transfer, however long the input stays high.
- R7: With DMA enable (control bit 4) set, an accepted trigger raises dma_req, and dma_req falls at the edge where dma_ack is high.
- R8: A trigger that arrives while dma_req is high and dma_ack is low sets the underflow flag (bit 0 of address 3). That trigger causes no transfer, and dma_req stays high.
- R9: An acknowledge in the same cycle as a trigger is taken as coming first. No underflow is flagged, the transfer happens and dma_req stays high.
- R10: Writing 1 to bit 0 of address 3 clears the underflow flag. Writing 0 to it has no effect.
- R11: The irq output is high exactly while the underflow flag is set and the interrupt enable (control bit 5) is set.
- R12: After an underflow, triggers cause neither a transfer nor a request until DMA enable has been written to 0 and then back to 1. Clearing the flag does not release the block.
- R13: The output is 12 bits wide. Data bits above bit 11 are ignored, and 4095 passes through unchanged. The holding register reads at address 1 and the output at address 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 4 | Register word address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered one cycle after the address |
| hw_trig | input | 7 | Asynchronous hardware trigger inputs |
| dma_req | output | 1 | DMA request level |
| dma_ack | input | 1 | DMA acknowledge pulse |
| dac_data | output | 12 | Output data register to the converter |
| irq | output | 1 | Underflow interrupt |

## Verification
The hardest case to reach from the ports is a trigger and an acknowledge landing on the same clock edge. Hardware triggers pass through a synchroniser, so their arrival cycle is hard to place. The bench therefore uses the software trigger, which is consumed at the edge after its write, and raises dma_ack in exactly that cycle. A full underflow, the blocked state and the release by toggling DMA enable are then driven in sequence. Between steps, the output, the request and the flag are read back to confirm that ignored triggers changed nothing.

// File: rtl/dacseq_pkg.sv
package dacseq_pkg;

   // register word addresses
   localparam int unsigned REG_CTRL  = 0;
   localparam int unsigned REG_HOLD  = 1;
   localparam int unsigned REG_SWTRG = 2;
   localparam int unsigned REG_STAT  = 3;
   localparam int unsigned REG_OUT   = 4;

   // control field positions (selector field starts at bit 1)
   localparam int unsigned CTRL_TEN_BIT = 0;
   localparam int unsigned CTRL_SEL_LSB = 1;

endpackage

// File: rtl/dacseq_edge_sync.sv
module dacseq_edge_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic pulse
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $fatal(1, "dacseq_edge_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;
   logic              last_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         chain_q <= '0;
         last_q  <= 1'b0;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], async_in};
         last_q  <= chain_q[STAGES-1];
      end
   end

   assign pulse = chain_q[STAGES-1] & ~last_q;

endmodule

// File: rtl/dacseq_trig_sel.sv
module dacseq_trig_sel #(
   parameter int unsigned NUM_HW = 7,
   parameter int unsigned SEL_W  = 3,
   parameter int unsigned STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_HW-1:0] hw_trig,
   input  logic              sw_pend,
   input  logic [SEL_W-1:0]  sel,
   output logic              trig_pulse
);

   localparam int unsigned NUM_CODES = 2 ** SEL_W;
   localparam int unsigned SW_CODE   = NUM_CODES - 1;

   generate
      if (NUM_HW > SW_CODE) begin : g_bad_width
         $fatal(1, "dacseq_trig_sel: NUM_HW exceeds the codes below the software code");
      end
   endgenerate

   logic [NUM_CODES-1:0] src_vec;

   generate
      for (genvar g = 0; g < NUM_CODES; g++) begin : g_src
         if (g < NUM_HW) begin : g_hw
            dacseq_edge_sync #(.STAGES(STAGES)) u_sync (
               .clk      (clk),
               .rst_n    (rst_n),
               .async_in (hw_trig[g]),
               .pulse    (src_vec[g])
            );
         end else if (g == SW_CODE) begin : g_sw
            assign src_vec[g] = sw_pend;
         end else begin : g_none
            assign src_vec[g] = 1'b0;
         end
      end
   endgenerate

   assign trig_pulse = src_vec[sel];

endmodule

// File: rtl/dacseq_dma_ctl.sv
module dacseq_dma_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic trig_req,
   input  logic dma_en,
   input  logic irq_en,
   input  logic dma_ack,
   input  logic flag_clr,
   output logic take,
   output logic dma_req,
   output logic udr_flag,
   output logic blocked,
   output logic irq
);

   logic underflow;

   // an acknowledge in the same cycle clears the way for the new trigger
   assign underflow = trig_req & dma_en & ~blocked & dma_req & ~dma_ack;
   assign take      = trig_req & ~blocked & ~underflow;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dma_req  <= 1'b0;
         udr_flag <= 1'b0;
         blocked  <= 1'b0;
      end else begin
         if (!dma_en) begin
            dma_req <= 1'b0;
            blocked <= 1'b0;
         end else begin
            if (take) begin
               dma_req <= 1'b1;
            end else if (dma_ack) begin
               dma_req <= 1'b0;
            end
            if (underflow) begin
               blocked <= 1'b1;
            end
         end
         if (underflow) begin
            udr_flag <= 1'b1;
         end else if (flag_clr) begin
            udr_flag <= 1'b0;
         end
      end
   end

   assign irq = udr_flag & irq_en;

endmodule

// File: rtl/dacseq_regs.sv
module dacseq_regs
   import dacseq_pkg::*;
#(
   parameter int unsigned ADDR_W = 4,
   parameter int unsigned DATA_W = 12,
   parameter int unsigned SEL_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic              take,
   input  logic              udr_flag,
   output logic              trig_en,
   output logic [SEL_W-1:0]  trig_sel,
   output logic              dma_en,
   output logic              irq_en,
   output logic              sw_pend,
   output logic              flag_clr,
   output logic [DATA_W-1:0] dac_data
);

   localparam int unsigned DMA_BIT = CTRL_SEL_LSB + SEL_W;
   localparam int unsigned IRQ_BIT = DMA_BIT + 1;
   localparam int unsigned CTRL_W  = IRQ_BIT + 1;

   generate
      if (DATA_W > 32 || CTRL_W > 32) begin : g_bad_data
         $fatal(1, "dacseq_regs: fields must fit the 32-bit bus");
      end
   endgenerate

   logic [DATA_W-1:0] hold_q;
   logic              wr_ctrl, wr_hold, wr_sw, wr_stat, sw_use;
   logic [31:0]       rd_mux;
   logic              unused_wdata;

   assign wr_ctrl  = bus_we && (bus_addr == ADDR_W'(REG_CTRL));
   assign wr_hold  = bus_we && (bus_addr == ADDR_W'(REG_HOLD));
   assign wr_sw    = bus_we && (bus_addr == ADDR_W'(REG_SWTRG));
   assign wr_stat  = bus_we && (bus_addr == ADDR_W'(REG_STAT));
   assign flag_clr = wr_stat & bus_wdata[0];
   assign sw_use   = trig_en && (trig_sel == {SEL_W{1'b1}});
   assign unused_wdata = ^bus_wdata;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         trig_en  <= 1'b0;
         trig_sel <= '0;
         dma_en   <= 1'b0;
         irq_en   <= 1'b0;
         hold_q   <= '0;
         dac_data <= '0;
         sw_pend  <= 1'b0;
      end else begin
         if (wr_ctrl) begin
            trig_en  <= bus_wdata[CTRL_TEN_BIT];
            trig_sel <= bus_wdata[CTRL_SEL_LSB +: SEL_W];
            dma_en   <= bus_wdata[DMA_BIT];
            irq_en   <= bus_wdata[IRQ_BIT];
         end
         if (wr_hold) begin
            hold_q <= bus_wdata[DATA_W-1:0];
         end
         if (take) begin
            dac_data <= hold_q;
         end else if (wr_hold && !trig_en) begin
            dac_data <= bus_wdata[DATA_W-1:0];
         end
         if (wr_sw && bus_wdata[0]) begin
            sw_pend <= 1'b1;
         end else if (sw_use) begin
            sw_pend <= 1'b0;
         end
      end
   end

   always_comb begin
      rd_mux = '0;
      case (bus_addr)
         ADDR_W'(REG_CTRL):  rd_mux[CTRL_W-1:0] = {irq_en, dma_en, trig_sel, trig_en};
         ADDR_W'(REG_HOLD):  rd_mux[DATA_W-1:0] = hold_q;
         ADDR_W'(REG_SWTRG): rd_mux[0]          = sw_pend;
         ADDR_W'(REG_STAT):  rd_mux[0]          = udr_flag;
         ADDR_W'(REG_OUT):   rd_mux[DATA_W-1:0] = dac_data;
         default:            rd_mux             = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bus_rdata <= '0;
      end else begin
         bus_rdata <= rd_mux;
      end
   end

endmodule

// File: rtl/dacseq_top.sv
module dacseq_top #(
   parameter int unsigned ADDR_W      = 4,
   parameter int unsigned DATA_W      = 12,
   parameter int unsigned NUM_HW      = 7,
   parameter int unsigned SEL_W       = 3,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic [NUM_HW-1:0] hw_trig,
   output logic              dma_req,
   input  logic              dma_ack,
   output logic [DATA_W-1:0] dac_data,
   output logic              irq
);

   generate
      if (ADDR_W < 3) begin : g_bad_addr
         $fatal(1, "dacseq_top: ADDR_W must cover five registers");
      end
   endgenerate

   logic             trig_en, dma_en, irq_en, sw_pend, flag_clr;
   logic [SEL_W-1:0] trig_sel;
   logic             trig_pulse, trig_req, take, udr_flag, blocked;

   assign trig_req = trig_pulse & trig_en;

   dacseq_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEL_W(SEL_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_we    (bus_we),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .take      (take),
      .udr_flag  (udr_flag),
      .trig_en   (trig_en),
      .trig_sel  (trig_sel),
      .dma_en    (dma_en),
      .irq_en    (irq_en),
      .sw_pend   (sw_pend),
      .flag_clr  (flag_clr),
      .dac_data  (dac_data)
   );

   dacseq_trig_sel #(.NUM_HW(NUM_HW), .SEL_W(SEL_W), .STAGES(SYNC_STAGES)) u_sel (
      .clk        (clk),
      .rst_n      (rst_n),
      .hw_trig    (hw_trig),
      .sw_pend    (sw_pend),
      .sel        (trig_sel),
      .trig_pulse (trig_pulse)
   );

   dacseq_dma_ctl u_dma (
      .clk      (clk),
      .rst_n    (rst_n),
      .trig_req (trig_req),
      .dma_en   (dma_en),
      .irq_en   (irq_en),
      .dma_ack  (dma_ack),
      .flag_clr (flag_clr),
      .take     (take),
      .dma_req  (dma_req),
      .udr_flag (udr_flag),
      .blocked  (blocked),
      .irq      (irq)
   );

endmodule

// File: rtl/dacseq_checker.sv
module dacseq_checker #(
   parameter int unsigned ADDR_W = 4,
   parameter int unsigned DATA_W = 12,
   parameter int unsigned SEL_W  = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_we,
   input logic [31:0]       bus_wdata,
   input logic              dma_req,
   input logic              dma_ack,
   input logic              dma_en,
   input logic              trig_en,
   input logic [SEL_W-1:0]  trig_sel,
   input logic              trig_req,
   input logic              sw_pend,
   input logic              blocked,
   input logic              udr_flag,
   input logic              irq,
   input logic [DATA_W-1:0] dac_data
);

   localparam logic [ADDR_W-1:0] A_HOLD = ADDR_W'(dacseq_pkg::REG_HOLD);
   localparam logic [ADDR_W-1:0] A_SW   = ADDR_W'(dacseq_pkg::REG_SWTRG);
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(dacseq_pkg::REG_STAT);

   assert_direct_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == A_HOLD && !trig_en) |=> dac_data == $past(bus_wdata[DATA_W-1:0]));

   assert_sw_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_pend && trig_en && trig_sel == {SEL_W{1'b1}} && !(bus_we && bus_addr == A_SW && bus_wdata[0]))
      |=> !sw_pend);

   assert_req_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dma_req) |-> ($past(trig_req) && $past(dma_en)));

   assert_req_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dma_req) |-> ($past(dma_ack) || !$past(dma_en)));

   assert_udr_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(udr_flag) |-> ($past(dma_req) && !$past(dma_ack) && $past(trig_req)));

   assert_ack_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_req && dma_ack && dma_req && dma_en && !blocked) |=> (dma_req && !$rose(udr_flag)));

   assert_flag_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(udr_flag) |-> ($past(bus_we) && $past(bus_addr) == A_STAT && $past(bus_wdata[0])));

   assert_w0_keeps_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (udr_flag && bus_we && bus_addr == A_STAT && !bus_wdata[0]) |=> udr_flag);

   assert_irq_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> udr_flag);

   assert_blocked_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (blocked && trig_en) |=> ($stable(dac_data) && !$rose(dma_req)));

endmodule

bind dacseq_top dacseq_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEL_W(SEL_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_we    (bus_we),
   .bus_wdata (bus_wdata),
   .dma_req   (dma_req),
   .dma_ack   (dma_ack),
   .dma_en    (dma_en),
   .trig_en   (trig_en),
   .trig_sel  (trig_sel),
   .trig_req  (trig_req),
   .sw_pend   (sw_pend),
   .blocked   (blocked),
   .udr_flag  (udr_flag),
   .irq       (irq),
   .dac_data  (dac_data)
);

// File: tb/dacseq_top_bench.sv
`timescale 1ns/100ps
module dacseq_top_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [6:0]  hw_trig = '0;
   logic        dma_req;
   logic        dma_ack = 1'b0;
   logic [11:0] dac_data;
   logic        irq;

   int checks = 0;
   int fails  = 0;
   logic [31:0] rv;

   always #2.5 clk = ~clk;

   dacseq_top u_dacseq_top (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .hw_trig(hw_trig),
      .dma_req(dma_req), .dma_ack(dma_ack), .dac_data(dac_data), .irq(irq)
   );

   // {select, source fired (7 = software), holding value, expected output}
   localparam logic [31:0] VEC [0:9] = '{
      {4'd0, 4'd0, 12'h111, 12'h111},
      {4'd1, 4'd1, 12'h222, 12'h222},
      {4'd2, 4'd5, 12'h333, 12'h222},
      {4'd3, 4'd3, 12'h444, 12'h444},
      {4'd4, 4'd4, 12'h555, 12'h555},
      {4'd5, 4'd6, 12'h666, 12'h555},
      {4'd6, 4'd6, 12'h777, 12'h777},
      {4'd7, 4'd7, 12'hFFF, 12'hFFF},
      {4'd7, 4'd0, 12'h123, 12'hFFF},
      {4'd5, 4'd5, 12'h0AB, 12'h0AB}
   };

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_we = 1'b1; bus_wdata = d;
      @(posedge clk);
      #1 bus_we = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a;
      @(posedge clk);
      @(negedge clk);
      d = bus_rdata;
   endtask

   task automatic idle(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic fire(input int src);
      if (src == 7) begin
         wr(4'd2, 32'h1);
         idle(2);
      end else begin
         @(negedge clk);
         hw_trig[src] = 1'b1;
         repeat (3) @(posedge clk);
         @(negedge clk);
         hw_trig[src] = 1'b0;
         idle(3);
      end
   endtask

   task automatic ack_pulse();
      @(negedge clk);
      dma_ack = 1'b1;
      @(posedge clk);
      #1 dma_ack = 1'b0;
      @(negedge clk);
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", checks - fails, checks);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      fails++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      chk("R1 dac_data", 32'(dac_data), 32'h0);
      chk("R1 dma_req", 32'(dma_req), 32'h0);
      chk("R1 irq", 32'(irq), 32'h0);
      rd(4'd0, rv); chk("R1 ctrl", rv, 32'h0);
      rd(4'd3, rv); chk("R1 status", rv, 32'h0);
      rd(4'd2, rv); chk("R1 swtrig", rv, 32'h0);

      // R2 and R3: source selection table in trigger mode
      for (int i = 0; i < 10; i++) begin
         wr(4'd0, 32'h1 | (32'(VEC[i][31:28]) << 1));
         wr(4'd1, 32'(VEC[i][23:12]));
         fire(int'(VEC[i][27:24]));
         chk($sformatf("R2 R3 vector %0d", i), 32'(dac_data), 32'(VEC[i][11:0]));
      end

      // R4 direct mode
      wr(4'd0, 32'h0);
      wr(4'd1, 32'h5A5);
      @(negedge clk);
      chk("R4 direct write", 32'(dac_data), 32'h5A5);
      fire(0);
      chk("R4 trigger ignored", 32'(dac_data), 32'h5A5);
      // R13 width
      wr(4'd1, 32'hFFFF_F123);
      @(negedge clk);
      chk("R13 upper bits dropped", 32'(dac_data), 32'h123);
      rd(4'd1, rv); chk("R13 hold readback", rv, 32'h123);
      wr(4'd1, 32'hFFF);
      rd(4'd4, rv); chk("R13 full scale", rv, 32'hFFF);

      // R5 software trigger
      wr(4'd0, 32'h0F);
      wr(4'd1, 32'h654);
      @(negedge clk);
      chk("R3 hold write alone", 32'(dac_data), 32'hFFF);
      fire(7);
      rd(4'd2, rv); chk("R5 bit self-clears", rv, 32'h0);
      chk("R5 transfer", 32'(dac_data), 32'h654);
      wr(4'd0, 32'h0D);
      wr(4'd2, 32'h1);
      idle(2);
      rd(4'd2, rv); chk("R5 bit stays pending", rv, 32'h1);
      chk("R5 no transfer while unselected", 32'(dac_data), 32'h654);
      wr(4'd1, 32'h789);
      wr(4'd0, 32'h0F);
      idle(2);
      rd(4'd2, rv); chk("R5 consumed on select", rv, 32'h0);
      chk("R5 pending transfer", 32'(dac_data), 32'h789);

      // R6 one transfer per rising edge
      wr(4'd0, 32'h01);
      wr(4'd1, 32'hA01);
      @(negedge clk); hw_trig[0] = 1'b1;
      idle(5);
      chk("R6 first edge", 32'(dac_data), 32'hA01);
      wr(4'd1, 32'hA02);
      idle(5);
      chk("R6 level held", 32'(dac_data), 32'hA01);
      hw_trig[0] = 1'b0;
      idle(5);
      chk("R6 falling edge", 32'(dac_data), 32'hA01);
      hw_trig[0] = 1'b1;
      idle(5);
      chk("R6 second edge", 32'(dac_data), 32'hA02);
      hw_trig[0] = 1'b0;
      idle(3);

      // R7 DMA request handshake
      wr(4'd0, 32'h3F);
      wr(4'd1, 32'h100);
      fire(7);
      chk("R7 request raised", 32'(dma_req), 32'h1);
      chk("R7 transfer", 32'(dac_data), 32'h100);
      ack_pulse();
      chk("R7 request dropped", 32'(dma_req), 32'h0);

      // R9 acknowledge in the trigger cycle
      wr(4'd1, 32'h200);
      fire(7);
      chk("R9 request before", 32'(dma_req), 32'h1);
      wr(4'd1, 32'h250);
      @(negedge clk);
      bus_addr = 4'd2; bus_we = 1'b1; bus_wdata = 32'h1;
      @(posedge clk);
      #1 bus_we = 1'b0;
      @(negedge clk);
      dma_ack = 1'b1;
      @(posedge clk);
      #1 dma_ack = 1'b0;
      @(negedge clk);
      chk("R9 request kept", 32'(dma_req), 32'h1);
      chk("R9 transfer", 32'(dac_data), 32'h250);
      rd(4'd3, rv); chk("R9 no underflow", rv, 32'h0);

      // R8 underflow
      wr(4'd1, 32'h300);
      fire(7);
      rd(4'd3, rv); chk("R8 flag set", rv, 32'h1);
      chk("R8 no transfer", 32'(dac_data), 32'h250);
      chk("R8 request held", 32'(dma_req), 32'h1);
      chk("R11 irq raised", 32'(irq), 32'h1);

      // R12 blocked
      ack_pulse();
      chk("R12 ack still drops request", 32'(dma_req), 32'h0);
      wr(4'd1, 32'h400);
      fire(7);
      chk("R12 blocked transfer", 32'(dac_data), 32'h250);
      chk("R12 blocked request", 32'(dma_req), 32'h0);

      // R10 write-1-to-clear
      wr(4'd3, 32'h0);
      rd(4'd3, rv); chk("R10 write 0 ignored", rv, 32'h1);
      chk("R10 irq after write 0", 32'(irq), 32'h1);
      wr(4'd3, 32'h1);
      rd(4'd3, rv); chk("R10 write 1 clears", rv, 32'h0);
      chk("R11 irq follows flag", 32'(irq), 32'h0);
      fire(7);
      chk("R12 still blocked after clear", 32'(dac_data), 32'h250);

      // R12 re-arm
      wr(4'd0, 32'h2F);
      wr(4'd0, 32'h3F);
      fire(7);
      chk("R12 re-armed transfer", 32'(dac_data), 32'h400);
      chk("R12 re-armed request", 32'(dma_req), 32'h1);

      // R11 interrupt gating
      wr(4'd0, 32'h1F);
      fire(7);
      rd(4'd3, rv); chk("R11 flag with irq off", rv, 32'h1);
      chk("R11 irq masked", 32'(irq), 32'h0);
      wr(4'd0, 32'h3F);
      @(negedge clk);
      chk("R11 irq unmasked", 32'(irq), 32'h1);

      summary();
      $finish;
   end

endmodule